// File: doc/BRIEF.md
# Segmented Address Relocation Unit

This block converts a 16-bit offset into a 20-bit physical byte address by adding it to one of four 16-bit segment bases: code, stack, data and extra. The segment base is shifted left by four bits before the add, so every segment starts on a 16-byte boundary and covers up to 64K bytes. The sum wraps modulo 2^20.

The requester states what kind of access it is making: an instruction fetch, a stack push or pop, a general memory reference, or the destination of a string operation. For a general memory reference it also states whether the offset was formed from the base-pointer register. From these the unit picks the default segment. A one-shot segment override can be armed ahead of the access. It replaces the default only for stack and general memory references. The next access that is not a fetch uses the override up, and then it is cleared. A write port loads the segment registers. Every accepted request gives a registered physical address, the segment actually used and a valid flag one cycle later.

Top module: `seg_reloc_unit`

## Requirements
- R1: After reset phys_valid is 0, no override is armed, the code segment holds FFFFh and the stack, data and extra segments hold 0000h.
- R2: phys_valid is 1 in exactly the cycle after each cycle with req_valid=1 and is 0 otherwise. phys_addr = ((segment << 4) + offset) mod 2^20, and phys_seg reports the segment used (0=code, 1=stack, 2=data, 3=extra).
- R3: A fetch (req_kind=0) always uses the code segment. It ignores any override and leaves an armed override armed.
- R4: A stack push or pop (req_kind=1) with no override uses the stack segment.
- R5: A general memory reference (req_kind=2) with no override uses the stack segment when req_bp_base=1 and the data segment when req_bp_base=0.
- R6: A string destination (req_kind=3) always uses the extra segment. It ignores any override but clears an armed one.
- R7: An armed override (ovr_valid=1 with ovr_seg in the R2 encoding) is applied to the next stack or general memory reference and is then cleared, so the reference after that falls back to its default.
- R8: An override presented in the same cycle as a request applies to that request. A newer override presented before the consuming access replaces the older one.
- R9: A segment write (seg_wr_en, seg_wr_sel in the R2 encoding) affects requests from the next cycle on. A request in the same cycle as the write uses the old value.
- R10: The relocation add wraps modulo 2^20. For example, segment FFFFh with offset 0010h gives 00000h, and with offset FFFFh it gives 0FFEFh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Address request this cycle |
| req_kind | input | 2 | 0 fetch, 1 stack push/pop, 2 memory reference, 3 string destination |
| req_bp_base | input | 1 | Memory reference offset is based on the base pointer |
| req_offset | input | 16 | Offset within the segment |
| ovr_valid | input | 1 | Arm a one-shot segment override |
| ovr_seg | input | 2 | Override segment |
| seg_wr_en | input | 1 | Segment register write enable |
| seg_wr_sel | input | 2 | Segment register to write |
| seg_wr_data | input | 16 | New segment value |
| phys_valid | output | 1 | Registered address is valid |
| phys_addr | output | 20 | Physical byte address |
| phys_seg | output | 2 | Segment used for this address |

## Verification
A stuck or leaking override latch appears in phys_seg of the first stack or memory reference after the access that should have consumed it, one cycle after that request. A segment register that is corrupted, or written a cycle early, appears in phys_addr of the next access that selects it. A wrong selection rule shows in phys_seg on the cycle after the offending request. Because the bench compares every cycle, each such fault shows up within one cycle of the first request that exposes it.

// File: rtl/seg_reloc_pkg.sv
package seg_reloc_pkg;

    typedef enum logic [1:0] {
        SEG_CODE  = 2'd0,
        SEG_STACK = 2'd1,
        SEG_DATA  = 2'd2,
        SEG_EXTRA = 2'd3
    } seg_id_e;

    typedef enum logic [1:0] {
        ACC_FETCH  = 2'd0,
        ACC_STACK  = 2'd1,
        ACC_MEM    = 2'd2,
        ACC_STRDST = 2'd3
    } acc_kind_e;

    localparam int NUM_SEGS = 4;

    typedef struct packed {
        logic    armed;
        seg_id_e seg;
    } ovr_state_t;

    function automatic logic ovr_allowed(acc_kind_e kind);
        return (kind == ACC_STACK) || (kind == ACC_MEM);
    endfunction

    function automatic logic consumes_ovr(acc_kind_e kind);
        return kind != ACC_FETCH;
    endfunction

    function automatic seg_id_e default_seg(acc_kind_e kind, logic bp_base);
        seg_id_e s;
        case (kind)
            ACC_FETCH:  s = SEG_CODE;
            ACC_STACK:  s = SEG_STACK;
            ACC_MEM:    s = bp_base ? SEG_STACK : SEG_DATA;
            default:    s = SEG_EXTRA;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/seg_regfile.sv
module seg_regfile
    import seg_reloc_pkg::*;
#(
    parameter int SEG_W    = 16,
    parameter logic [SEG_W-1:0] CODE_RST = '1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  seg_id_e          wr_sel,
    input  logic [SEG_W-1:0] wr_data,
    input  seg_id_e          rd_sel,
    output logic [SEG_W-1:0] rd_data
);

    logic [SEG_W-1:0] regs [NUM_SEGS];

    for (genvar g = 0; g < NUM_SEGS; g++) begin : g_seg
        localparam logic [SEG_W-1:0] RST_VAL = (g == int'(SEG_CODE)) ? CODE_RST : '0;
        always_ff @(posedge clk) begin
            if (rst) begin
                regs[g] <= RST_VAL;
            end else if (wr_en && (wr_sel == seg_id_e'(g))) begin
                regs[g] <= wr_data;
            end
        end
    end

    assign rd_data = regs[rd_sel];

endmodule

// File: rtl/seg_selector.sv
module seg_selector
    import seg_reloc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       req_valid,
    input  acc_kind_e  req_kind,
    input  logic       req_bp_base,
    input  logic       ovr_valid,
    input  seg_id_e    ovr_seg,
    output seg_id_e    sel_seg,
    output logic       pend_armed
);

    ovr_state_t pend_q;
    ovr_state_t eff;
    logic       consume;

    // A freshly presented override takes priority over the stored one.
    always_comb begin
        if (ovr_valid) begin
            eff.armed = 1'b1;
            eff.seg   = ovr_seg;
        end else begin
            eff = pend_q;
        end
    end

    always_comb begin
        if (eff.armed && ovr_allowed(req_kind)) begin
            sel_seg = eff.seg;
        end else begin
            sel_seg = default_seg(req_kind, req_bp_base);
        end
    end

    assign consume = req_valid && consumes_ovr(req_kind);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '{armed: 1'b0, seg: SEG_CODE};
        end else if (consume) begin
            pend_q <= '{armed: 1'b0, seg: SEG_CODE};
        end else begin
            pend_q <= eff;
        end
    end

    assign pend_armed = pend_q.armed;

endmodule

// File: rtl/seg_adder.sv
module seg_adder
    import seg_reloc_pkg::*;
#(
    parameter int SEG_W = 16,
    parameter int OFF_W = 16,
    parameter int SHIFT = 4,
    localparam int PA_W = SEG_W + SHIFT
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  seg_id_e          in_seg,
    input  logic [SEG_W-1:0] in_base,
    input  logic [OFF_W-1:0] in_offset,
    output logic             out_valid,
    output seg_id_e          out_seg,
    output logic [PA_W-1:0]  out_addr
);

    logic [PA_W-1:0] shifted;
    logic [PA_W-1:0] sum;

    assign shifted = {in_base, {SHIFT{1'b0}}};
    assign sum     = shifted + PA_W'(in_offset);

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_seg   <= SEG_CODE;
            out_addr  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_seg  <= in_seg;
                out_addr <= sum;
            end
        end
    end

endmodule

// File: rtl/seg_reloc_unit.sv
module seg_reloc_unit
    import seg_reloc_pkg::*;
#(
    parameter int SEG_W = 16,
    parameter int OFF_W = 16,
    parameter int SHIFT = 4,
    parameter logic [SEG_W-1:0] CODE_RST = '1,
    localparam int PA_W = SEG_W + SHIFT
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic [1:0]       req_kind,
    input  logic             req_bp_base,
    input  logic [OFF_W-1:0] req_offset,
    input  logic             ovr_valid,
    input  logic [1:0]       ovr_seg,
    input  logic             seg_wr_en,
    input  logic [1:0]       seg_wr_sel,
    input  logic [SEG_W-1:0] seg_wr_data,
    output logic             phys_valid,
    output logic [PA_W-1:0]  phys_addr,
    output logic [1:0]       phys_seg
);

    seg_id_e          sel_seg;
    seg_id_e          out_seg;
    logic [SEG_W-1:0] base;
    logic             pend_armed;

    seg_selector u_sel (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_kind   (acc_kind_e'(req_kind)),
        .req_bp_base(req_bp_base),
        .ovr_valid  (ovr_valid),
        .ovr_seg    (seg_id_e'(ovr_seg)),
        .sel_seg    (sel_seg),
        .pend_armed (pend_armed)
    );

    seg_regfile #(.SEG_W(SEG_W), .CODE_RST(CODE_RST)) u_regs (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (seg_wr_en),
        .wr_sel (seg_id_e'(seg_wr_sel)),
        .wr_data(seg_wr_data),
        .rd_sel (sel_seg),
        .rd_data(base)
    );

    seg_adder #(.SEG_W(SEG_W), .OFF_W(OFF_W), .SHIFT(SHIFT)) u_add (
        .clk      (clk),
        .rst      (rst),
        .in_valid (req_valid),
        .in_seg   (sel_seg),
        .in_base  (base),
        .in_offset(req_offset),
        .out_valid(phys_valid),
        .out_seg  (out_seg),
        .out_addr (phys_addr)
    );

    assign phys_seg = out_seg;

endmodule

// File: rtl/seg_reloc_chk.sv
module seg_reloc_chk (
    input logic       clk,
    input logic       rst,
    input logic       req_valid,
    input logic [1:0] req_kind,
    input logic       req_bp_base,
    input logic       ovr_valid,
    input logic       pend_armed,
    input logic       phys_valid,
    input logic [1:0] phys_seg
);

    // R2
    valid_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> phys_valid);

    // R2
    no_spurious_valid_chk: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !phys_valid);

    // R3
    fetch_uses_code_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_kind == 2'd0) |=> (phys_seg == 2'd0));

    // R6
    strdst_uses_extra_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_kind == 2'd3) |=> (phys_seg == 2'd3));

    // R5
    mem_default_data_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_kind == 2'd2 && !req_bp_base && !ovr_valid && !pend_armed)
        |=> (phys_seg == 2'd2));

    // R7
    ovr_cleared_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_kind != 2'd0) |=> !pend_armed);

endmodule

bind seg_reloc_unit seg_reloc_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_kind   (req_kind),
    .req_bp_base(req_bp_base),
    .ovr_valid  (ovr_valid),
    .pend_armed (pend_armed),
    .phys_valid (phys_valid),
    .phys_seg   (phys_seg)
);

// File: tb/tb_seg_reloc_unit.sv
`timescale 1ns/1ps
module tb_seg_reloc_unit;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic [1:0]  req_kind;
    logic        req_bp_base;
    logic [15:0] req_offset;
    logic        ovr_valid;
    logic [1:0]  ovr_seg;
    logic        seg_wr_en;
    logic [1:0]  seg_wr_sel;
    logic [15:0] seg_wr_data;
    logic        phys_valid;
    logic [19:0] phys_addr;
    logic [1:0]  phys_seg;

    always #4 clk = ~clk;

    seg_reloc_unit dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_kind(req_kind), .req_bp_base(req_bp_base),
        .req_offset(req_offset), .ovr_valid(ovr_valid), .ovr_seg(ovr_seg),
        .seg_wr_en(seg_wr_en), .seg_wr_sel(seg_wr_sel), .seg_wr_data(seg_wr_data),
        .phys_valid(phys_valid), .phys_addr(phys_addr), .phys_seg(phys_seg)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference model state
    int unsigned m_seg [4];
    bit          m_pv;
    int unsigned m_ps;

    task automatic check(string tag, bit exp_v, int unsigned exp_a, int unsigned exp_s);
        checks++;
        if (phys_valid !== exp_v) begin
            errors++;
            $display("FAIL %s valid: actual %0b expected %0b", tag, phys_valid, exp_v);
        end else if (exp_v && (phys_addr !== exp_a[19:0] || phys_seg !== exp_s[1:0])) begin
            errors++;
            $display("FAIL %s addr/seg: actual %05h/%0d expected %05h/%0d",
                     tag, phys_addr, phys_seg, exp_a[19:0], exp_s);
        end
    endtask

    // Drive at negedge, update model, check at the following negedge.
    task automatic step(bit rq, int unsigned kind, bit bp, int unsigned off,
                        bit ov, int unsigned os, bit we, int unsigned ws,
                        int unsigned wd, string tag);
        bit          have;
        int unsigned s;
        int unsigned sel;
        int unsigned ea;
        req_valid = rq; req_kind = kind[1:0]; req_bp_base = bp; req_offset = off[15:0];
        ovr_valid = ov; ovr_seg = os[1:0];
        seg_wr_en = we; seg_wr_sel = ws[1:0]; seg_wr_data = wd[15:0];
        have = ov || m_pv;
        s    = ov ? os : m_ps;
        if (kind == 0) sel = 0;
        else if (kind == 3) sel = 3;
        else if (have) sel = s;
        else if (kind == 1) sel = 1;
        else sel = bp ? 1 : 2;
        ea = ((m_seg[sel] * 16) + off) % 32'h100000;
        if (rq && kind != 0) m_pv = 0;
        else if (ov) begin m_pv = 1; m_ps = os; end
        if (we) m_seg[ws] = wd;
        @(posedge clk);
        @(negedge clk);
        check(tag, rq, ea, sel);
    endtask

    task automatic idle(string tag);
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, tag);
    endtask

    initial begin
        #1000000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1; req_valid = 0; req_kind = 0; req_bp_base = 0; req_offset = 0;
        ovr_valid = 0; ovr_seg = 0; seg_wr_en = 0; seg_wr_sel = 0; seg_wr_data = 0;
        m_seg[0] = 32'hFFFF; m_seg[1] = 0; m_seg[2] = 0; m_seg[3] = 0;
        m_pv = 0; m_ps = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        check("R1", 0, 0, 0);

        // R1: reset segment values
        step(1, 0, 0, 16'h0005, 0, 0, 0, 0, 0, "R1");
        step(1, 1, 0, 16'h1234, 0, 0, 0, 0, 0, "R1");
        step(1, 2, 0, 16'h00FF, 0, 0, 0, 0, 0, "R1");

        // R9: load segments, idle cycles give no valid (R2)
        step(0, 0, 0, 0, 0, 0, 1, 0, 16'h1234, "R2");
        step(0, 0, 0, 0, 0, 0, 1, 1, 16'h2000, "R2");
        step(0, 0, 0, 0, 0, 0, 1, 2, 16'h3000, "R2");
        step(0, 0, 0, 0, 0, 0, 1, 3, 16'h4000, "R2");

        // R3 / R4 / R5 / R6 defaults, back to back (R2)
        step(1, 0, 0, 16'h0100, 0, 0, 0, 0, 0, "R3");
        step(1, 1, 0, 16'hFFFE, 0, 0, 0, 0, 0, "R4");
        step(1, 2, 0, 16'h0010, 0, 0, 0, 0, 0, "R5");
        step(1, 2, 1, 16'h0020, 0, 0, 0, 0, 0, "R5");
        step(1, 3, 0, 16'h0030, 0, 0, 0, 0, 0, "R6");

        // R9: same-cycle write uses the old value, next sees new
        step(1, 2, 0, 16'h0001, 0, 0, 1, 2, 16'h5000, "R9");
        step(1, 2, 0, 16'h0001, 0, 0, 0, 0, 0, "R9");

        // R7 / R3: fetch ignores and keeps override; mem consumes
        step(0, 0, 0, 0, 1, 3, 0, 0, 0, "R7");
        step(1, 0, 0, 16'h0040, 0, 0, 0, 0, 0, "R3");
        step(1, 2, 0, 16'h0050, 0, 0, 0, 0, 0, "R7");
        step(1, 2, 0, 16'h0050, 0, 0, 0, 0, 0, "R7");

        // R7: override on stack push
        step(0, 0, 0, 0, 1, 2, 0, 0, 0, "R7");
        idle("R7");
        step(1, 1, 0, 16'h0060, 0, 0, 0, 0, 0, "R7");
        step(1, 1, 0, 16'h0060, 0, 0, 0, 0, 0, "R7");

        // R6: string destination ignores but clears override
        step(0, 0, 0, 0, 1, 0, 0, 0, 0, "R6");
        step(1, 3, 0, 16'h0070, 0, 0, 0, 0, 0, "R6");
        step(1, 2, 1, 16'h0070, 0, 0, 0, 0, 0, "R6");
        // override presented with string dest itself
        step(1, 3, 0, 16'h0071, 1, 1, 0, 0, 0, "R6");
        step(1, 2, 0, 16'h0072, 0, 0, 0, 0, 0, "R6");

        // R8: same-cycle override applies; newer replaces older
        step(1, 1, 0, 16'h0080, 1, 3, 0, 0, 0, "R8");
        step(1, 1, 0, 16'h0080, 0, 0, 0, 0, 0, "R8");
        step(0, 0, 0, 0, 1, 0, 0, 0, 0, "R8");
        step(0, 0, 0, 0, 1, 2, 0, 0, 0, "R8");
        step(1, 2, 1, 16'h0090, 0, 0, 0, 0, 0, "R8");
        step(1, 2, 1, 16'h0090, 0, 0, 0, 0, 0, "R8");
        // override arriving with a fetch is kept for later
        step(1, 0, 0, 16'h00A0, 1, 1, 0, 0, 0, "R8");
        step(1, 2, 0, 16'h00A0, 0, 0, 0, 0, 0, "R8");

        // R10: wrap of the 20-bit add
        step(0, 0, 0, 0, 0, 0, 1, 2, 16'hFFFF, "R10");
        step(1, 2, 0, 16'h0010, 0, 0, 0, 0, 0, "R10");
        step(1, 2, 0, 16'hFFFF, 0, 0, 0, 0, 0, "R10");
        step(1, 2, 0, 16'h000F, 0, 0, 0, 0, 0, "R10");

        // R1: reset again restores defaults and clears override
        step(0, 0, 0, 0, 1, 3, 0, 0, 0, "R1");
        rst = 1;
        @(posedge clk);
        @(negedge clk);
        rst = 0;
        m_seg[0] = 32'hFFFF; m_seg[1] = 0; m_seg[2] = 0; m_seg[3] = 0;
        m_pv = 0;
        check("R1", 0, 0, 0);
        step(1, 2, 0, 16'h0123, 0, 0, 0, 0, 0, "R1");
        step(1, 0, 0, 16'h0000, 0, 0, 0, 0, 0, "R1");
        idle("R2");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule